// File: doc/BRIEF.md
# Inter-processor interrupt claim controller

This block raises software interrupts between up to eight harts. It is built like a platform-level interrupt controller. Each interrupt source stands for one ordered pair of harts: the source number is `sender*8 + target`. A hart sends an interrupt by writing a one to the sender's bit in the pending array. The target hart takes the interrupt through its claim/complete register and later hands it back there.

Every source has a priority. Every target context has a 64-bit enable mask. A hart's interrupt line is high while at least one source is pending, enabled for that hart, not in service and has a nonzero priority. A claim read returns the best such source and takes it out of the pending set in the same cycle. The source stays in service until the same ID is written back to that context. All access goes through a single 32-bit register port. A read's data appears on `rsp_rdata` after the clock edge that accepts the read.

Top module: `ipi_claim_ctrl`

## Requirements
- R1: A write to a pending word sets every pending bit whose write-data bit is 1. Bits written as 0 keep their value. Word 0 (byte offset 0x1000) covers sources 0–31 and word 1 (0x1004) covers sources 32–63, with bit n of a word standing for source 32*word+n. Reads of these words return the pending bits.
- R2: Source 0 (hart 0 to itself) never becomes pending, its priority always reads 0, and it can never raise an interrupt.
- R3: Source s has a priority register at byte offset 4*s. It keeps the low PRIO_W bits of a write and reads back zero-extended. A source whose priority is 0 is never claimed and never raises an interrupt.
- R4: The enable mask of context i sits at 0x2000 + 0x80*i. The word at +0 covers sources 0–31 and the word at +4 covers sources 32–63. The masks read back as written.
- R5: A read of the claim/complete register of context i (byte offset 0x200000 + 0x1000*i + 4) returns the ID of the pending, enabled, not-in-service source with the highest nonzero priority. On a tie the lowest ID wins. The read returns 0 if no source qualifies.
- R6: A claim read that returns a nonzero ID clears that source's pending bit and puts the source in service. While in service the source is not returned by any claim, even if it is set pending again. Writing the ID to the claim/complete register of a context that enables it ends the service.
- R7: A write of an ID to a context's claim/complete register has no effect if that context does not enable the ID.
- R8: Output `irq_o[i]` is registered. It equals the presence of a claimable source for context i as it stood one clock earlier, so it changes one cycle after the state change that causes it.
- R9: Reads of unmapped addresses return 0.
- R10: After reset all pending, in-service, priority and enable state is 0, every `irq_o` bit is 0 and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered, held until the next read |
| irq_o | output | NHARTS | Software interrupt line per target hart |

## Verification
On every cycle the assertions check the following. A claim takes the winner out of the pending set and marks it in service. Pending bits only grow outside a claim. The arbiter's winner is always a pending, enabled, idle source with nonzero priority, and it reports no winner only when no such source exists. An interrupt line rises only when the cycle before held a pending, enabled source that was not in service. Only the bench's scenarios can show the rest: tie-breaking by lowest ID, the hidden in-service state after a repeated send, ignored completions from the wrong context, the one-cycle lag of `irq_o`, and the self-send and priority-zero cases that stay silent.

// File: rtl/ipi_ctrl_pkg.sv
// Package: constants shared by the interrupt claim controller.
// Assumes eight source slots per sender, so source = sender*8 + target.
package ipi_ctrl_pkg;
    localparam int SLOTS = 8;
    localparam int NSRC  = SLOTS * SLOTS;
    localparam int ID_W  = $clog2(NSRC);

    // Mask of sources that can exist for a given hart count; source 0 excluded.
    function automatic logic [NSRC-1:0] src_mask(input int nharts);
        logic [NSRC-1:0] m;
        m = '0;
        for (int s = 1; s < NSRC; s++)
            m[s] = ((s / SLOTS) < nharts) && ((s % SLOTS) < nharts);
        return m;
    endfunction
endpackage

// File: rtl/ipi_src_state.sv
// Pending and in-service bits for every source.
// Assumes at most one of set/claim per cycle (single register port).
module ipi_src_state
    import ipi_ctrl_pkg::*;
#(
    parameter logic [NSRC-1:0] MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic            claim_fire,
    input  logic [ID_W-1:0] claim_id,
    input  logic            done_fire,
    input  logic [ID_W-1:0] done_id,
    output logic [NSRC-1:0] pending,
    output logic [NSRC-1:0] inprog
);
    // Pending: write-1-to-set, cleared by a claim of that source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            logic [NSRC-1:0] nxt;
            nxt = (pending | set_vec) & MASK;
            if (claim_fire) nxt[claim_id] = 1'b0;
            pending <= nxt;
        end
    end

    // In-service: set by claim, cleared by a matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inprog <= '0;
        end else begin
            logic [NSRC-1:0] nxt;
            nxt = inprog;
            if (done_fire) nxt[done_id] = 1'b0;
            if (claim_fire) nxt[claim_id] = 1'b1;
            inprog <= nxt & MASK;
        end
    end

    AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |=> (!pending[$past(claim_id)] && inprog[$past(claim_id)])); // R6
    AST_W1S_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_fire |=> ((pending & $past(pending)) == $past(pending))); // R1
endmodule

// File: rtl/ipi_claim_arb.sv
// Per-context arbiter: picks the highest-priority claimable source,
// lowest ID on ties, 0 when nothing qualifies. Purely combinational.
module ipi_claim_arb
    import ipi_ctrl_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        pending,
    input  logic [NSRC-1:0]        inprog,
    input  logic [NSRC-1:0]        enable,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output logic [ID_W-1:0]        best_id
);
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] nz;
    logic [PRIO_W-1:0] best_p;

    // Which sources could be claimed by this context at all.
    always_comb begin
        elig = pending & enable & ~inprog;
        for (int s = 0; s < NSRC; s++) nz[s] = |prio_flat[s*PRIO_W +: PRIO_W];
    end

    // Linear scan; strict compare keeps the lowest ID on equal priority.
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int s = 1; s < NSRC; s++) begin
            if (elig[s] && prio_flat[s*PRIO_W +: PRIO_W] > best_p) begin
                best_p  = prio_flat[s*PRIO_W +: PRIO_W];
                best_id = ID_W'(s);
            end
        end
    end

    AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id != '0) |-> (pending[best_id] && enable[best_id] && !inprog[best_id] && nz[best_id])); // R5
    AST_NONE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id == '0) |-> ((elig & nz) == '0)); // R5
endmodule

// File: rtl/ipi_claim_ctrl.sv
// Top: register decode, priority and enable storage, claim/complete handling
// and registered per-hart interrupt lines. Assumes ADDR_W >= 22 and
// word-aligned accesses; one access per cycle.
module ipi_claim_ctrl
    import ipi_ctrl_pkg::*;
#(
    parameter int NHARTS = 8,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic [NHARTS-1:0] irq_o
);
    localparam logic [NSRC-1:0]   MASK      = src_mask(NHARTS);
    localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(32'h0000_1000);
    localparam logic [ADDR_W-1:0] EN_BASE   = ADDR_W'(32'h0000_2000);
    localparam logic [ADDR_W-1:0] CLM_BASE  = ADDR_W'(32'h0020_0000);

    logic [PRIO_W-1:0]      prio_q [NSRC];
    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic [NSRC-1:0]        en_q [SLOTS];
    logic [ID_W-1:0]        best_id [SLOTS];
    logic [NSRC-1:0]        pending, inprog, set_vec;
    logic                   aligned, is_prio, is_pend, is_en, is_clm;
    logic [2:0]             en_ctx, clm_ctx;
    logic                   claim_fire, done_fire;
    logic [ID_W-1:0]        done_id;
    logic [31:0]            rd_val;

    // Address decode for the four register regions.
    always_comb begin
        aligned = (req_addr[1:0] == 2'b00);
        en_ctx  = req_addr[9:7];
        clm_ctx = req_addr[14:12];
        is_prio = aligned && (req_addr[ADDR_W-1:8] == '0);
        is_pend = aligned && (req_addr[ADDR_W-1:3] == PEND_BASE[ADDR_W-1:3]);
        is_en   = aligned && (req_addr[ADDR_W-1:10] == EN_BASE[ADDR_W-1:10])
                  && (req_addr[6:3] == '0) && (int'(en_ctx) < NHARTS);
        is_clm  = aligned && (req_addr[ADDR_W-1:15] == CLM_BASE[ADDR_W-1:15])
                  && (req_addr[11:2] == 10'd1) && (int'(clm_ctx) < NHARTS);
    end

    // Side-effect strobes: send, claim and completion.
    always_comb begin
        set_vec = '0;
        if (req_valid && req_write && is_pend) begin
            if (req_addr[2]) set_vec[63:32] = req_wdata;
            else             set_vec[31:0]  = req_wdata;
        end
        claim_fire = req_valid && !req_write && is_clm && (best_id[clm_ctx] != '0);
        done_id    = req_wdata[ID_W-1:0];
        done_fire  = req_valid && req_write && is_clm && (req_wdata[31:ID_W] == '0)
                     && en_q[clm_ctx][done_id];
    end

    // Priority registers; non-existent sources stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSRC; s++) prio_q[s] <= '0;
        end else if (req_valid && req_write && is_prio && MASK[req_addr[7:2]]) begin
            prio_q[req_addr[7:2]] <= req_wdata[PRIO_W-1:0];
        end
    end

    // Enable masks, one 64-bit mask per existing context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < SLOTS; c++) en_q[c] <= '0;
        end else if (req_valid && req_write && is_en) begin
            if (req_addr[2]) en_q[en_ctx][63:32] <= req_wdata & MASK[63:32];
            else             en_q[en_ctx][31:0]  <= req_wdata & MASK[31:0];
        end
    end

    genvar gs, gc;
    generate
        for (gs = 0; gs < NSRC; gs++) begin : g_flat
            assign prio_flat[gs*PRIO_W +: PRIO_W] = prio_q[gs];
        end
    endgenerate

    ipi_src_state #(.MASK(MASK)) u_state (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .claim_fire(claim_fire), .claim_id(best_id[clm_ctx]),
        .done_fire(done_fire), .done_id(done_id),
        .pending(pending), .inprog(inprog)
    );

    generate
        for (gc = 0; gc < SLOTS; gc++) begin : g_ctx
            if (gc < NHARTS) begin : g_live
                ipi_claim_arb #(.PRIO_W(PRIO_W)) u_arb (
                    .clk(clk), .rst_n(rst_n), .pending(pending), .inprog(inprog),
                    .enable(en_q[gc]), .prio_flat(prio_flat), .best_id(best_id[gc])
                );

                // Registered interrupt line for this hart.
                always_ff @(posedge clk) begin
                    if (!rst_n) irq_o[gc] <= 1'b0;
                    else        irq_o[gc] <= (best_id[gc] != '0);
                end

                AST_IRQ_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(irq_o[gc]) |-> $past(|(pending & en_q[gc] & ~inprog))); // R8
            end else begin : g_dead
                assign best_id[gc] = '0;
            end
        end
    endgenerate

    // Read data mux; unmapped space reads zero.
    always_comb begin
        rd_val = '0;
        if (is_prio)     rd_val = 32'(prio_q[req_addr[7:2]]);
        else if (is_pend) rd_val = req_addr[2] ? pending[63:32] : pending[31:0];
        else if (is_en)   rd_val = req_addr[2] ? en_q[en_ctx][63:32] : en_q[en_ctx][31:0];
        else if (is_clm)  rd_val = 32'(best_id[clm_ctx]);
    end

    // Registered read response, held until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rsp_rdata <= '0;
        else if (req_valid && !req_write) rsp_rdata <= rd_val;
    end
endmodule

// File: tb/ipi_claim_ctrl_bench.sv
module ipi_claim_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [NH-1:0] irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_claim_ctrl #(.NHARTS(NH), .PRIO_W(3), .ADDR_W(22)) u_ipi_claim_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [21:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 22'h000004, 32'd3,         32'd0,         "R3"},
        '{1'b0, 22'h000004, 32'd0,         32'd3,         "R3"},
        '{1'b1, 22'h000024, 32'd5,         32'd0,         "R3"},
        '{1'b1, 22'h000044, 32'd5,         32'd0,         "R3"},
        '{1'b1, 22'h002080, 32'h02020202,  32'd0,         "R4"},
        '{1'b1, 22'h002084, 32'h02020202,  32'd0,         "R4"},
        '{1'b0, 22'h002084, 32'd0,         32'h02020202,  "R4"},
        '{1'b1, 22'h001000, 32'h00020203,  32'd0,         "R2"},
        '{1'b0, 22'h001000, 32'd0,         32'h00020202,  "R2"},
        '{1'b0, 22'h201004, 32'd0,         32'd9,         "R5"},
        '{1'b0, 22'h201004, 32'd0,         32'd17,        "R5"},
        '{1'b0, 22'h201004, 32'd0,         32'd1,         "R5"},
        '{1'b0, 22'h201004, 32'd0,         32'd0,         "R5"},
        '{1'b0, 22'h001000, 32'd0,         32'd0,         "R6"},
        '{1'b1, 22'h001000, 32'h00000200,  32'd0,         "R6"},
        '{1'b0, 22'h001000, 32'd0,         32'h00000200,  "R1"},
        '{1'b0, 22'h201004, 32'd0,         32'd0,         "R6"},
        '{1'b1, 22'h202004, 32'd9,         32'd0,         "R7"},
        '{1'b0, 22'h201004, 32'd0,         32'd0,         "R7"},
        '{1'b1, 22'h201004, 32'd9,         32'd0,         "R6"},
        '{1'b0, 22'h201004, 32'd0,         32'd9,         "R6"},
        '{1'b1, 22'h001000, 32'h02000000,  32'd0,         "R3"},
        '{1'b0, 22'h201004, 32'd0,         32'd0,         "R3"},
        '{1'b0, 22'h001000, 32'd0,         32'h02000000,  "R1"},
        '{1'b0, 22'h003000, 32'd0,         32'd0,         "R9"},
        '{1'b1, 22'h000000, 32'd7,         32'd0,         "R2"},
        '{1'b0, 22'h000000, 32'd0,         32'd0,         "R2"},
        '{1'b1, 22'h000004, 32'hFFFFFFFF,  32'd0,         "R3"},
        '{1'b0, 22'h000004, 32'd0,         32'd7,         "R3"},
        '{1'b1, 22'h201004, 32'd1,         32'd0,         "R6"},
        '{1'b1, 22'h001000, 32'h00000002,  32'd0,         "R1"},
        '{1'b0, 22'h001000, 32'd0,         32'h02000002,  "R1"},
        '{1'b0, 22'h201004, 32'd0,         32'd1,         "R5"},
        '{1'b0, 22'h000FF0, 32'd0,         32'd0,         "R9"}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge; returns at the next falling edge.
    task automatic access(input logic wr, input logic [21:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10: reset state
        check(32'(irq_o), 32'd0, "R10");
        check(rsp_rdata, 32'd0, "R10");

        for (int i = 0; i < NV; i++) begin
            access(TABLE[i].wr, TABLE[i].addr, TABLE[i].data);
            if (!TABLE[i].wr) check(rsp_rdata, TABLE[i].exp, string'(TABLE[i].tag));
        end

        do_reset();
        access(1'b0, 22'h001000, 32'd0);
        check(rsp_rdata, 32'd0, "R10");
        access(1'b0, 22'h000004, 32'd0);
        check(rsp_rdata, 32'd0, "R10");
        check(32'(irq_o), 32'd0, "R10");

        // R8: interrupt line lags the send by one cycle
        access(1'b1, 22'h000084, 32'd2);
        access(1'b1, 22'h002084, 32'h00000002);
        access(1'b1, 22'h001004, 32'h00000002);
        check(32'(irq_o), 32'd0, "R8");
        @(negedge clk);
        check(32'(irq_o), 32'h02, "R8");
        access(1'b0, 22'h201004, 32'd0);
        check(rsp_rdata, 32'd33, "R5");
        check(32'(irq_o), 32'h02, "R8");
        @(negedge clk);
        check(32'(irq_o), 32'h00, "R8");
        access(1'b1, 22'h201004, 32'd33);
        @(negedge clk);
        check(32'(irq_o), 32'h00, "R6");

        // R2: hart 0 sending to itself raises nothing
        access(1'b1, 22'h002000, 32'h01010101);
        access(1'b1, 22'h000000, 32'd7);
        access(1'b1, 22'h001000, 32'h00000001);
        repeat (2) @(negedge clk);
        check(32'(irq_o), 32'h00, "R2");

        // R8: hart 1 to hart 0 (source 8) raises hart 0's line only
        access(1'b1, 22'h000020, 32'd1);
        access(1'b1, 22'h001000, 32'h00000100);
        repeat (2) @(negedge clk);
        check(32'(irq_o), 32'h01, "R8");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule